// File: doc/BRIEF.md
# Duplex Selection and Collision Test Control

This block decides the duplex mode that an Ethernet PHY runs in and produces the collision signal while the management-controlled collision test is running. The duplex can come from four places: a board strap pin when the hardware/software mode input selects hardware mode, the auto-negotiation result when negotiation is enabled, a forced full duplex while loopback is active, or a duplex bit in the control register.

The block holds the writable part of the control register slice it owns. That slice has a duplex bit at position 8, a collision-test enable at position 7, and seven reserved bits at positions 6..0. The collision test makes COL follow TXEN through a fixed delay that is counted in bit times on a bit-time clock enable. A status output reports the duplex of the active link and reads half duplex while the link is down.

Top module: `phy_dpx_coltest`

## Requirements
- R1: After reset `dpx_full`, `dpx_status` and `col` are 0, and `ctl_rdata` reads 0 (duplex bit and collision-test bit both reset to 0).
- R2: With `sw_mode`=0 (hardware mode), `dpx_full` takes the value of `dpx_pin` on the clock edge after it is sampled. The register duplex bit and loopback have no effect.
- R3: With `sw_mode`=1 and `an_enable`=1, `dpx_full` takes the value of `an_full` on the next clock edge, whatever the register duplex bit holds.
- R4: With `sw_mode`=1, `an_enable`=0 and `loopback`=0, `dpx_full` follows register bit 8: 0 gives half duplex (0) and 1 gives full duplex (1).
- R5: With `sw_mode`=1, `an_enable`=0 and `loopback`=1, register bit 8 has no effect and `dpx_full` is 1.
- R6: `dpx_status` is registered together with `dpx_full`. It equals the selected duplex when `link_up`=1 and is 0 when `link_up`=0.
- R7: While collision-test bit 7 reads 0, `col` stays 0 whatever `txen` does.
- R8: While bit 7 is 1, `col` follows `txen` delayed by exactly 2 bit times, in loopback as well. `txen` is sampled on each clock edge where `bit_tick`=1, and `col` changes on the edge of the second such sample. Setting bit 7 clears the delay history, and clearing it drops `col` on the next edge.
- R9: Bits 6..0 of `ctl_rdata` always read 0, and writes to them are ignored.
- R10: A write with `ctl_wr`=1 loads bits 8 and 7 from `ctl_wdata`. The new values are visible on `ctl_rdata` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle enable per bit time |
| sw_mode | input | 1 | 0 = hardware strap mode, 1 = software mode |
| dpx_pin | input | 1 | Strap duplex select, 1 = full |
| an_enable | input | 1 | Auto-negotiation enabled |
| an_full | input | 1 | Auto-negotiation duplex result, 1 = full |
| loopback | input | 1 | Loopback active |
| link_up | input | 1 | Link is up |
| txen | input | 1 | MII transmit enable |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 9 | Control write data, bits 8..0 |
| ctl_rdata | output | 9 | Control read data, bits 8..0 |
| dpx_full | output | 1 | Effective duplex, 1 = full |
| dpx_status | output | 1 | Duplex status of the active link |
| col | output | 1 | Collision output during collision test |

## Verification
A register write that clears or sets the collision-test bit can land in the same cycle as a bit tick that carries a TXEN edge. Likewise, a write to the duplex bit can coincide with a change of mode inputs. The bench drives ticks, TXEN and writes from independent pseudo-random sources, so these collisions happen many times. A behavioural model, which applies every write after the old enable has decided whether the history shifts or clears, is compared with `col`, `dpx_full`, `dpx_status` and `ctl_rdata` on every clock.

// File: rtl/phy_dpx_coltest.sv
module phy_dpx_coltest #(
  parameter int COL_DELAY = 2,
  parameter int CTL_W     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             sw_mode,
  input  logic             dpx_pin,
  input  logic             an_enable,
  input  logic             an_full,
  input  logic             loopback,
  input  logic             link_up,
  input  logic             txen,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  output logic             dpx_full,
  output logic             dpx_status,
  output logic             col
);
  localparam int DPX_POS = CTL_W - 1;
  localparam int CT_POS  = CTL_W - 2;
  localparam int RSV_W   = CTL_W - 2;

  logic                 dpx_bit_q, coltest_q, dpx_q, stat_q;
  logic [COL_DELAY-1:0] hist_q;
  logic                 dpx_next;

  always_comb begin
    if (!sw_mode)       dpx_next = dpx_pin;
    else if (an_enable) dpx_next = an_full;
    else if (loopback)  dpx_next = 1'b1;
    else                dpx_next = dpx_bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dpx_bit_q <= 1'b0;
      coltest_q <= 1'b0;
      dpx_q     <= 1'b0;
      stat_q    <= 1'b0;
      hist_q    <= '0;
    end else begin
      dpx_q  <= dpx_next;
      stat_q <= dpx_next & link_up;
      if (!coltest_q)    hist_q <= '0;
      else if (bit_tick) hist_q <= (hist_q << 1) | COL_DELAY'(txen);
      if (ctl_wr) begin
        dpx_bit_q <= ctl_wdata[DPX_POS];
        coltest_q <= ctl_wdata[CT_POS];
      end
    end
  end

  assign ctl_rdata  = {dpx_bit_q, coltest_q, {RSV_W{1'b0}}};
  assign dpx_full   = dpx_q;
  assign dpx_status = stat_q;
  assign col        = coltest_q & hist_q[COL_DELAY-1];
endmodule

module phy_dpx_coltest_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic       sw_mode,
  input logic       dpx_pin,
  input logic       an_enable,
  input logic       an_full,
  input logic       link_up,
  input logic [8:0] ctl_rdata,
  input logic       dpx_full,
  input logic       dpx_status,
  input logic       col
);
  a_r2_strap_pin: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_mode |=> dpx_full == $past(dpx_pin));
  a_r3_an_result: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_mode && an_enable) |=> dpx_full == $past(an_full));
  a_r6_link_down: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> !dpx_status);
  a_r6_status_dpx: assert property (@(posedge clk) disable iff (!rst_n)
    dpx_status |-> dpx_full);
  a_r7_col_gated: assert property (@(posedge clk) disable iff (!rst_n)
    col |-> ctl_rdata[7]);
  a_r8_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col) |-> $past(bit_tick));
  a_r9_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[6:0] == 7'd0);
endmodule

bind phy_dpx_coltest phy_dpx_coltest_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sw_mode(sw_mode),
  .dpx_pin(dpx_pin), .an_enable(an_enable), .an_full(an_full),
  .link_up(link_up), .ctl_rdata(ctl_rdata), .dpx_full(dpx_full),
  .dpx_status(dpx_status), .col(col)
);

// File: tb/phy_dpx_coltest_test.sv
module phy_dpx_coltest_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_tick = 0, sw_mode = 1, dpx_pin = 0, an_enable = 0, an_full = 0;
  logic loopback = 0, link_up = 0, txen = 0, ctl_wr = 0;
  logic [8:0] ctl_wdata = '0;
  logic [8:0] ctl_rdata;
  logic dpx_full, dpx_status, col;
  int errors = 0, checks = 0, cyc = 0;
  bit m_dpx = 0, m_ct = 0, e_dpx = 0, e_stat = 0;
  bit hist[$];
  int unsigned lfsr = 32'h1ACE5EED;

  always #4 clk = ~clk;

  phy_dpx_coltest uut (.*);

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_dpx = 0; m_ct = 0; e_dpx = 0; e_stat = 0; hist.delete();
    end else begin
      bit sel;
      if (!sw_mode) sel = dpx_pin;
      else if (an_enable) sel = an_full;
      else if (loopback) sel = 1;
      else sel = m_dpx;
      e_dpx = sel; e_stat = sel & link_up;
      if (!m_ct) hist.delete();
      else if (bit_tick) begin
        hist.push_front(txen);
        if (hist.size() > 2) void'(hist.pop_back());
      end
      if (ctl_wr) begin m_dpx = ctl_wdata[8]; m_ct = ctl_wdata[7]; end
    end
  end

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp_v, cyc);
    end
  endtask

  function automatic string dpx_req();
    if (!sw_mode) return "R2";
    if (an_enable) return "R3";
    if (loopback) return "R5";
    return "R4";
  endfunction

  string last_req = "R4";
  task automatic compare();
    bit ecol;
    ecol = m_ct && hist.size() == 2 && hist[1];
    chk(last_req, {8'd0, dpx_full}, {8'd0, e_dpx});
    chk("R6", {8'd0, dpx_status}, {8'd0, e_stat});
    chk(m_ct ? "R8" : "R7", {8'd0, col}, {8'd0, ecol});
    chk("R9", {2'd0, ctl_rdata[6:0]}, 9'd0);
    chk("R10", {7'd0, ctl_rdata[8:7]}, {7'd0, m_dpx, m_ct});
  endtask

  function automatic bit rnd(input int pct);
    lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
    return (lfsr % 100) < pct;
  endfunction

  task automatic step(input int mode_sel, input int wr_pct, input int ct_pct);
    @(negedge clk);
    compare();
    bit_tick = rnd(30);
    txen = rnd(50) ? ~txen : txen;
    dpx_pin = rnd(20) ? ~dpx_pin : dpx_pin;
    an_full = rnd(20) ? ~an_full : an_full;
    link_up = rnd(10) ? ~link_up : link_up;
    ctl_wr = rnd(wr_pct);
    ctl_wdata = {rnd(50), rnd(ct_pct), 7'h7F};
    case (mode_sel)
      0: begin sw_mode = 0; loopback = rnd(50); end
      1: begin sw_mode = 1; an_enable = 1; end
      2: begin sw_mode = 1; an_enable = 0; loopback = 0; end
      default: begin sw_mode = 1; an_enable = 0; loopback = 1; end
    endcase
    last_req = dpx_req();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R1", {dpx_full, dpx_status, col, 6'd0}, 9'd0);
        chk("R1", ctl_rdata, 9'd0);
        rst_n = 1;
        for (int k = 0; k < 4; k++)
          for (int i = 0; i < 400; i++) step(k, 15, 60);
        for (int i = 0; i < 800; i++) step(i % 4, 40, 50);
        for (int i = 0; i < 400; i++) step(3, 5, 90);
        @(negedge clk); compare();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule